// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block turns one request into the strobe, select and hold timing of a synchronous external memory bus for a single chip-select region. The request carries an address, a direction, one write data word and a burst length. The sequencer places the address on the bus with a one-cycle latch strobe, or a stretched one. It asserts the active-low chip select after a programmable setup delay and ends each beat with an internal or an external acknowledge. After the final beat it holds the address (and the write data) for a programmable time, then reports completion.

Timing comes from static configuration inputs: setup code, strobe stretch, read and write hold codes, a primary and a secondary wait-state count with an enable for the secondary one, and an auto-acknowledge enable. Beats after the first in a burst may use the secondary wait count. Read hold time is one cycle shorter when auto-acknowledge is on. Read data for each beat is returned with a one-cycle valid pulse.

Top module: `ebus_cycle_seq`

## Requirements
- R1: After reset, chip select is high, the strobe, write flag, done and read-valid are low, address and write data outputs are zero, and the request port is ready.
- R2: Chip select first goes low exactly setup+1 cycles after the first strobe cycle (setup code 0..3); the strobe starts while chip select is still high.
- R3: With stretch disabled, the strobe is high for exactly one cycle per transfer.
- R4: With stretch enabled, the strobe stays high through the first chip-select cycle, i.e. setup+2 cycles in all.
- R5: With auto-acknowledge on, every beat keeps chip select low for primary+1 cycles, for primary counts 0 to 63.
- R6: With the secondary enable set, beats after the first of a burst last secondary+1 cycles; with it clear, the secondary count has no effect and all beats use the primary count.
- R7: With auto-acknowledge off, a beat ends only at the clock edge where the external acknowledge is sampled high; the wait counts have no effect.
- R8: After a read, the address stays on the bus for code cycles (auto-acknowledge on) or code+1 cycles (auto-acknowledge off) after chip select negates.
- R9: After a write, address, write data and write flag stay on the bus for code+1 cycles (1 to 4) after chip select negates.
- R10: In a burst of len+1 beats (len 0..3), chip select stays low across beats, the address rises by one per beat, and hold time follows only the last beat.
- R11: done pulses for one cycle, in the first cycle after the hold period; in that cycle chip select is high and the address output is zero.
- R12: Read data is sampled at the edge that ends each beat and is presented on rsp_rdata_o with rsp_valid_o high in the following cycle.
- R13: For a write, the write data and write flag are driven from the first strobe cycle to the end of hold; for a read both stay zero.
- R14: A request is accepted only while req_ready_o is high, which happens only when no transfer is in progress; a request raised during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_setup_i | input | 2 | Setup code, select asserts setup+1 cycles after strobe |
| cfg_ext_latch_i | input | 1 | Stretch strobe until select appears |
| cfg_rd_hold_i | input | 2 | Read hold code |
| cfg_wr_hold_i | input | 2 | Write hold code |
| cfg_wait_i | input | WW (6) | Primary wait-state count |
| cfg_wait2_i | input | WW (6) | Secondary wait-state count |
| cfg_wait2_en_i | input | 1 | Use secondary count for later burst beats |
| cfg_auto_ack_i | input | 1 | Internal acknowledge after wait count |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_addr_i | input | AW (16) | Start address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW (16) | Write data word |
| req_len_i | input | LW (2) | Beats minus one |
| ext_ack_i | input | 1 | External beat acknowledge |
| bus_rdata_i | input | DW (16) | Read data from bus |
| bus_cs_no | output | 1 | Active-low chip select |
| bus_ale_o | output | 1 | Address latch / transfer start strobe |
| bus_addr_o | output | AW (16) | Bus address |
| bus_wdata_o | output | DW (16) | Bus write data |
| bus_wr_o | output | 1 | Write direction attribute |
| rsp_rdata_o | output | DW (16) | Captured read data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench targets the hold arithmetic, where a read with auto-acknowledge on and code 0 must give zero hold while the same code on a write gives one; a design that shares one formula would be one cycle off in one direction. Bursts with secondary waits enabled and disabled expose a design that reloads the wrong count, or that inserts hold between beats and so briefly releases chip select. Stretched strobes with each setup code catch off-by-one release of the strobe, a 63-cycle wait catches counter truncation, and external-acknowledge runs with a large primary count catch a design that ends beats on the timer. A request raised mid-transfer would, in a design that accepts it, start a stray strobe seen in the idle window that follows.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD
  } phase_e;

  // hold cycles after select negates
  function automatic logic [2:0] hold_cycles(input logic       is_wr,
                                             input logic [1:0] rd_code,
                                             input logic [1:0] wr_code,
                                             input logic       auto_ack);
    if (is_wr)         return {1'b0, wr_code} + 3'd1;
    else if (auto_ack) return {1'b0, rd_code};
    else               return {1'b0, rd_code} + 3'd1;
  endfunction

endpackage

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
  parameter int WW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          second_i,
  input  logic          run_i,
  input  logic [WW-1:0] cfg_wait_i,
  input  logic [WW-1:0] cfg_wait2_i,
  input  logic          cfg_wait2_en_i,
  output logic          expired_o
);

  logic [WW-1:0] cnt_q;
  logic [WW-1:0] load_val;

  assign load_val  = (second_i && cfg_wait2_en_i) ? cfg_wait2_i : cfg_wait_i;
  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - WW'(1);
    end
  end

endmodule

// File: rtl/ebus_phase_fsm.sv
module ebus_phase_fsm
  import ebus_seq_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_fire_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [1:0]    cfg_setup_i,
  input  logic          cfg_ext_latch_i,
  input  logic [2:0]    hold_len_i,
  input  logic          beat_end_i,
  output phase_e        phase_o,
  output logic          ale_o,
  output logic          beat_load_o,
  output logic          beat_second_o,
  output logic          last_beat_o,
  output logic          done_o
);

  phase_e        phase_q;
  logic [2:0]    cnt_q;
  logic [LW-1:0] beats_left_q;
  logic          first_q;
  logic          ext_tail_q;
  logic          done_q;
  logic          setup_end;

  assign setup_end     = (phase_q == PH_SETUP) && (cnt_q == 3'd0);
  assign last_beat_o   = (beats_left_q == '0);
  assign beat_load_o   = setup_end ||
                         ((phase_q == PH_ACTIVE) && beat_end_i && !last_beat_o);
  assign beat_second_o = (phase_q == PH_ACTIVE);
  assign phase_o       = phase_q;
  assign done_o        = done_q;
  assign ale_o         = ((phase_q == PH_SETUP) && (first_q || cfg_ext_latch_i)) ||
                         ((phase_q == PH_ACTIVE) && cfg_ext_latch_i && ext_tail_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      beats_left_q <= '0;
      first_q      <= 1'b0;
      ext_tail_q   <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_fire_i) begin
            phase_q      <= PH_SETUP;
            cnt_q        <= {1'b0, cfg_setup_i};
            beats_left_q <= req_len_i;
            first_q      <= 1'b1;
          end
        end
        PH_SETUP: begin
          first_q <= 1'b0;
          if (cnt_q == 3'd0) begin
            phase_q    <= PH_ACTIVE;
            ext_tail_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 3'd1;
          end
        end
        PH_ACTIVE: begin
          ext_tail_q <= 1'b0;
          if (beat_end_i) begin
            if (last_beat_o) begin
              if (hold_len_i == 3'd0) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                phase_q <= PH_HOLD;
                cnt_q   <= hold_len_i - 3'd1;
              end
            end else begin
              beats_left_q <= beats_left_q - LW'(1);
            end
          end
        end
        PH_HOLD: begin
          if (cnt_q == 3'd0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 3'd1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  a_r3_short_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ext_latch_i && ale_o) |=> !ale_o);

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_fire_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  input  logic          beat_end_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          write_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_wr_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_valid_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (req_fire_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      write_q <= req_write_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  // sample on the edge that ends a read beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= beat_end_i && !write_q;
      if (beat_end_i && !write_q) rdata_q <= bus_rdata_i;
    end
  end

  assign write_o     = write_q;
  assign bus_addr_o  = busy_i ? addr_q : '0;
  assign bus_wr_o    = busy_i && write_q;
  assign bus_wdata_o = (busy_i && write_q) ? wdata_q : '0;
  assign rsp_rdata_o = rdata_q;
  assign rsp_valid_o = rvalid_q;

endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
  import ebus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 6,
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_setup_i,
  input  logic          cfg_ext_latch_i,
  input  logic [1:0]    cfg_rd_hold_i,
  input  logic [1:0]    cfg_wr_hold_i,
  input  logic [WW-1:0] cfg_wait_i,
  input  logic [WW-1:0] cfg_wait2_i,
  input  logic          cfg_wait2_en_i,
  input  logic          cfg_auto_ack_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          ext_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_cs_no,
  output logic          bus_ale_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_wr_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_valid_o,
  output logic          done_o
);

  phase_e     phase;
  logic       req_fire;
  logic       beat_end;
  logic       beat_load;
  logic       beat_second;
  logic       last_beat;
  logic       wait_expired;
  logic       write_q;
  logic [2:0] hold_len;

  assign req_ready_o = (phase == PH_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign bus_cs_no   = (phase != PH_ACTIVE);
  assign beat_end    = (phase == PH_ACTIVE) &&
                       (cfg_auto_ack_i ? wait_expired : ext_ack_i);
  assign hold_len    = hold_cycles(write_q, cfg_rd_hold_i, cfg_wr_hold_i, cfg_auto_ack_i);

  ebus_phase_fsm #(.LW(LW)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_fire_i      (req_fire),
    .req_len_i       (req_len_i),
    .cfg_setup_i     (cfg_setup_i),
    .cfg_ext_latch_i (cfg_ext_latch_i),
    .hold_len_i      (hold_len),
    .beat_end_i      (beat_end),
    .phase_o         (phase),
    .ale_o           (bus_ale_o),
    .beat_load_o     (beat_load),
    .beat_second_o   (beat_second),
    .last_beat_o     (last_beat),
    .done_o          (done_o)
  );

  ebus_wait_timer #(.WW(WW)) u_wait (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (beat_load),
    .second_i       (beat_second),
    .run_i          (phase == PH_ACTIVE),
    .cfg_wait_i     (cfg_wait_i),
    .cfg_wait2_i    (cfg_wait2_i),
    .cfg_wait2_en_i (cfg_wait2_en_i),
    .expired_o      (wait_expired)
  );

  ebus_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .req_wdata_i (req_wdata_i),
    .busy_i      (phase != PH_IDLE),
    .step_i      (beat_end && !last_beat),
    .beat_end_i  (beat_end),
    .bus_rdata_i (bus_rdata_i),
    .write_o     (write_q),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  a_r2_strobe_before_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ale_o) |-> bus_cs_no);

  a_r4_strobe_covers_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ext_latch_i && $fell(bus_cs_no)) |-> bus_ale_o);

  a_r7_ext_ack_ends_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_auto_ack_i && rsp_valid_o) |-> $past(ext_ack_i));

  a_r9_write_hold_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && $rose(bus_cs_no)) |-> !done_o);

  a_r14_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bus_cs_no && !bus_wr_o && !bus_ale_o));

endmodule

// File: tb/ebus_cycle_seq_test.sv
module ebus_cycle_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 6;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_setup = '0;
  logic          cfg_ext = 1'b0;
  logic [1:0]    cfg_rdh = '0;
  logic [1:0]    cfg_wrh = '0;
  logic [WW-1:0] cfg_w = '0;
  logic [WW-1:0] cfg_w2 = '0;
  logic          cfg_w2en = 1'b0;
  logic          cfg_auto = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic          ext_ack = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          cs_n, ale, wr, done, rvalid;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int n_chk = 0;
  int n_fail = 0;
  int ack_delay = 1;
  bit timeout = 0;

  typedef struct {
    int            ale_n;
    int            gap;
    int            csn;
    int            hold;
    bit            wr;
    logic [DW-1:0] wd;
    logic [AW-1:0] last_addr;
    string         ale_tag;
    string         cs_tag;
    string         hold_tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] rd_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3c5a;
  endfunction

  assign bus_rdata = mem_f(addr);

  ebus_cycle_seq #(.AW(AW), .DW(DW), .WW(WW), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_setup_i(cfg_setup), .cfg_ext_latch_i(cfg_ext),
    .cfg_rd_hold_i(cfg_rdh), .cfg_wr_hold_i(cfg_wrh),
    .cfg_wait_i(cfg_w), .cfg_wait2_i(cfg_w2), .cfg_wait2_en_i(cfg_w2en),
    .cfg_auto_ack_i(cfg_auto),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write),
    .req_wdata_i(req_wdata), .req_len_i(req_len),
    .ext_ack_i(ext_ack), .bus_rdata_i(bus_rdata),
    .bus_cs_no(cs_n), .bus_ale_o(ale), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .bus_wr_o(wr),
    .rsp_rdata_o(rdata), .rsp_valid_o(rvalid), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // external acknowledge: high on the ack_delay-th select cycle of each beat (R7)
  int beat_k = 0;
  always @(negedge clk) begin
    if (cfg_auto || cs_n) begin
      ext_ack <= 1'b0;
      beat_k = 0;
    end else begin
      beat_k++;
      if (beat_k == ack_delay) begin
        ext_ack <= 1'b1;
        beat_k = 0;
      end else begin
        ext_ack <= 1'b0;
      end
    end
  end

  // monitor
  bit act_t = 0;
  int t, ale_n, gap, csn, hold, addr_err, data_err, rdy_err;
  bit cs_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (rd_q.size() == 0) chk(0, "R12 unexpected read data", int'(rdata), 0);
        else begin
          logic [DW-1:0] e;
          e = rd_q.pop_front();
          chk(rdata == e, "R12 read data", int'(rdata), int'(e));
        end
      end
      if (!act_t && ale) begin
        act_t = 1; t = 0; ale_n = 0; gap = -1; csn = 0; hold = 0;
        addr_err = 0; data_err = 0; rdy_err = 0; cs_seen = 0;
        if (exp_q.size() == 0) chk(0, "R14 transfer without accepted request", 1, 0);
      end
      if (act_t && exp_q.size() > 0) begin
        if (ale) ale_n++;
        if (!done && req_ready) rdy_err++;
        if (!done && ((wr != exp_q[0].wr) ||
                      (wdata != (exp_q[0].wr ? exp_q[0].wd : '0)))) data_err++;
        if (!cs_n) begin
          if (!cs_seen) begin cs_seen = 1; gap = t; end
          csn++;
        end else if (cs_seen && !done) begin
          hold++;
          if (addr != exp_q[0].last_addr) addr_err++;
        end
        if (done) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(ale_n == e.ale_n, e.ale_tag, ale_n, e.ale_n);
          chk(gap == e.gap, "R2 setup gap", gap, e.gap);
          chk(csn == e.csn, e.cs_tag, csn, e.csn);
          chk(hold == e.hold, e.hold_tag, hold, e.hold);
          chk(addr_err == 0, "R10 address held at last beat", addr_err, 0);
          chk(data_err == 0, "R13 write data and flag window", data_err, 0);
          chk(rdy_err == 0, "R14 ready low while busy", rdy_err, 0);
          chk(cs_n && addr == '0, "R11 done cycle idle bus", int'(addr), 0);
          chk(rd_q.size() == 0, "R12 all read beats returned", rd_q.size(), 0);
          act_t = 0;
        end
        t++;
      end
    end
  end

  task automatic set_cfg(input int setup, input bit ext, input int rdh, input int wrh,
                         input int w, input int w2, input bit w2en, input bit au,
                         input int ackd);
    @(negedge clk);
    cfg_setup = 2'(setup); cfg_ext = ext; cfg_rdh = 2'(rdh); cfg_wrh = 2'(wrh);
    cfg_w = WW'(w); cfg_w2 = WW'(w2); cfg_w2en = w2en; cfg_auto = au;
    ack_delay = ackd;
  endtask

  task automatic txn(input bit is_wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int len, input bit stray);
    exp_t e;
    int sw;
    e.ale_n = cfg_ext ? int'(cfg_setup) + 2 : 1;
    e.ale_tag = cfg_ext ? "R4 stretched strobe length" : "R3 single strobe length";
    e.gap = int'(cfg_setup) + 1;
    if (cfg_auto) begin
      sw = cfg_w2en ? int'(cfg_w2) : int'(cfg_w);
      e.csn = int'(cfg_w) + 1 + len * (sw + 1);
      e.cs_tag = "R5 R6 R10 select low cycles";
    end else begin
      e.csn = (len + 1) * ack_delay;
      e.cs_tag = "R7 R10 select low cycles";
    end
    if (is_wr) begin
      e.hold = int'(cfg_wrh) + 1;
      e.hold_tag = "R9 write hold";
    end else begin
      e.hold = cfg_auto ? int'(cfg_rdh) : int'(cfg_rdh) + 1;
      e.hold_tag = "R8 read hold";
    end
    e.wr = is_wr;
    e.wd = d;
    e.last_addr = a + AW'(len);
    exp_q.push_back(e);
    if (!is_wr) for (int k = 0; k <= len; k++) rd_q.push_back(mem_f(a + AW'(k)));
    @(negedge clk);
    req_valid = 1'b1; req_write = is_wr; req_addr = a; req_wdata = d; req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h7777; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic idle_window;
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ale || !cs_n || wr) bad++;
    end
    chk(bad == 0, "R14 stray request ignored", bad, 0);
  endtask

  task automatic run_tests;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset select high", int'(cs_n), 1);
    chk(!ale && !wr && !done && !rvalid, "R1 reset strobes low",
        int'({ale, wr, done, rvalid}), 0);
    chk(addr == '0 && wdata == '0, "R1 reset bus zero", int'(addr), 0);
    chk(req_ready, "R1 reset ready", int'(req_ready), 1);

    set_cfg(0, 0, 0, 0, 0, 0, 0, 1, 1);
    txn(0, 16'h0100, 16'h0, 0, 0);
    set_cfg(3, 1, 2, 0, 5, 0, 0, 1, 1);
    txn(0, 16'h1234, 16'h0, 0, 0);
    set_cfg(1, 1, 3, 0, 40, 7, 1, 0, 3);
    txn(0, 16'h2000, 16'h0, 0, 0);
    set_cfg(0, 0, 0, 0, 40, 0, 0, 0, 2);
    txn(0, 16'h2100, 16'h0, 0, 0);
    set_cfg(1, 0, 3, 0, 2, 0, 0, 1, 1);
    txn(1, 16'h3000, 16'hbeef, 0, 0);
    set_cfg(2, 1, 0, 3, 1, 0, 0, 1, 1);
    txn(1, 16'h3100, 16'h5a5a, 0, 0);
    set_cfg(0, 0, 1, 0, 2, 1, 1, 1, 1);
    txn(0, 16'h40fe, 16'h0, 3, 0);
    set_cfg(0, 0, 1, 0, 2, 9, 0, 1, 1);
    txn(0, 16'h5000, 16'h0, 3, 0);
    set_cfg(1, 1, 0, 1, 30, 0, 1, 0, 4);
    txn(1, 16'h6000, 16'hc3c3, 2, 0);
    set_cfg(0, 0, 0, 0, 63, 0, 0, 1, 1);
    txn(0, 16'h7000, 16'h0, 0, 0);
    set_cfg(1, 0, 1, 1, 6, 0, 0, 1, 1);
    txn(0, 16'h8000, 16'h0, 1, 1);
    idle_window();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) chk(0, "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule